// File: doc/BRIEF.md
# Fixed Off-Time Chopping Current Regulator

This block regulates the current in one winding of a bipolar motor by chopping its full bridge. Each chopping cycle starts with a drive phase. In that phase one diagonal pair of switches is on, so current builds up in the winding with the commanded polarity. An analog comparator outside the block reports when the sensed current reaches the trip level. That report ends the drive phase. A fixed off-time then follows, counted in clock cycles. During it the current decays in one of three ways: slow decay keeps only the low-side switch of the pair on, fast decay opens every switch, and mixed decay runs fast for a programmed number of cycles and slow for the rest.

The comparator is masked for a blanking window at the start of every drive phase, so switching transients cannot end the drive early. The translator supplies three things: whether the new current level is lower than the previous one, an analog fast-decay setting digitised to `PFD_W` bits, and a flag marking a zero target current. A fault or a low enable opens the bridge until the condition goes away. The off-time, the blanking time and the fast-decay portion are configuration inputs given in clock cycles.

Top module: `pwmChopper`

## Requirements
- R1: During reset, and from the first clock edge at which `fault` is high or `enable` is low, `phase` is OFF (code 0) and all four gate outputs are low. This holds for as long as the condition lasts.
- R2: In the drive phase (code 1), `polarity`=0 turns on `hiA` and `loB` only, and `polarity`=1 turns on `hiB` and `loA` only. The first edge after the OFF condition clears, with `dacZero` low, enters the drive phase.
- R3: The comparator is ignored during the first `blankCycles` cycles of every drive phase. With `tripIn` held high, a drive phase lasts exactly `blankCycles`+1 cycles.
- R4: The off-time lasts exactly `offCycles` cycles, with 0 treated as 1. The drive phase is then re-entered with a fresh blanking window, even if the comparator is still high.
- R5: Slow decay (code 3) turns on only the low-side switch of the driving pair: `loB` for polarity 0, `loA` for polarity 1.
- R6: Fast decay (code 2) turns every gate output off.
- R7: The decay style is picked at the edge that ends the drive phase and holds for that whole off-time. With `currentFalling` low it is slow. With `currentFalling` high and FS = 2^PFD_W-1, the style depends on `pfdLevel`: above floor(0.6·FS) (153 for 8 bits) it is slow; below floor(0.21·FS) (53 for 8 bits) it is fast for the whole off-time; otherwise it is mixed.
- R8: Mixed decay spends its first min(`fastCycles`, off-time) cycles in fast decay and the remaining cycles in slow decay.
- R9: From the edge at which `dacZero` is high, with no fault and with enable high, the bridge stays in slow decay and never drives. When `dacZero` clears, a drive phase with full blanking begins at the next edge.
- R10: Fault and disable take priority over `dacZero` and over the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Bridge enable, active high |
| fault | input | 1 | Fault condition, forces bridge off |
| tripIn | input | 1 | Comparator: current reached trip level |
| dacZero | input | 1 | Target current is zero |
| polarity | input | 1 | Winding current direction |
| currentFalling | input | 1 | New current level lower than previous |
| pfdLevel | input | PFD_W | Digitised fast-decay setting |
| offCycles | input | CNT_W | Off-time in clock cycles |
| blankCycles | input | CNT_W | Blanking window in clock cycles |
| fastCycles | input | CNT_W | Fast portion of mixed decay in cycles |
| phase | output | 2 | 0 off, 1 drive, 2 fast decay, 3 slow decay |
| hiA | output | 1 | High-side gate, leg A |
| loA | output | 1 | Low-side gate, leg A |
| hiB | output | 1 | High-side gate, leg B |
| loB | output | 1 | Low-side gate, leg B |

## Verification
The key collision is the end of an off-time landing on a cycle where the comparator is still high. At that edge the regulator must re-enter drive, and the blanking restart must hold the drive open for the full window. The bench provokes this by holding `tripIn` high through every vector and timing two successive drive phases, each of which must last `blankCycles`+1 cycles. A second collision is a fault arriving together with a high comparator and a zero-current flag. That case is judged by requiring OFF on the very next cycle and slow decay only after the fault clears.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_DRIVE = 2'd1,
    PH_FAST  = 2'd2,
    PH_SLOW  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'd0,
    DK_FAST  = 2'd1,
    DK_MIXED = 2'd2
  } decay_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic   loadBlank;
    logic   loadOff;
    decay_e decayMode;
  } chop_strobe_t;

endpackage

// File: rtl/chopTimers.sv
module chopTimers
  import chop_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chop_strobe_t     strobe,
  input  logic [CNT_W-1:0] offCycles,
  input  logic [CNT_W-1:0] blankCycles,
  input  logic [CNT_W-1:0] fastCycles,
  output logic             blankDone,
  output logic             offLast,
  output logic             fastActive
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] blankLeft;
  logic [CNT_W-1:0] offLeft;
  logic [CNT_W-1:0] fastLeft;
  logic [CNT_W-1:0] offEff;
  logic [CNT_W-1:0] fastLen;

  // a zero off-time still lasts one cycle
  assign offEff = (offCycles == '0) ? ONE : offCycles;

  // fast portion chosen by decay style, clamped to the off-time
  always_comb begin
    case (strobe.decayMode)
      DK_FAST:  fastLen = offEff;
      DK_MIXED: fastLen = (fastCycles < offEff) ? fastCycles : offEff;
      default:  fastLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankLeft <= '0;
      offLeft   <= '0;
      fastLeft  <= '0;
    end else begin
      if (strobe.loadBlank)     blankLeft <= blankCycles;
      else if (blankLeft != '0) blankLeft <= blankLeft - ONE;

      if (strobe.loadOff)       offLeft <= offEff;
      else if (offLeft != '0)   offLeft <= offLeft - ONE;

      if (strobe.loadOff)       fastLeft <= fastLen;
      else if (fastLeft != '0)  fastLeft <= fastLeft - ONE;
    end
  end

  assign blankDone  = (blankLeft == '0);
  assign offLast    = (offLeft == ONE);
  assign fastActive = (fastLeft != '0);

  AST_FAST_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOff |=> (fastLeft <= offLeft));  // R8

  AST_OFF_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOff |=> (offLeft != '0));  // R4

endmodule

// File: rtl/chopControl.sv
module chopControl
  import chop_pkg::*;
#(
  parameter int PFD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             fault,
  input  logic             tripIn,
  input  logic             dacZero,
  input  logic             currentFalling,
  input  logic [PFD_W-1:0] pfdLevel,
  input  logic             blankDone,
  input  logic             offLast,
  input  logic             fastActive,
  output chop_strobe_t     strobe,
  output phase_e           phase
);

  localparam int FULL_SCALE = (2 ** PFD_W) - 1;
  localparam logic [PFD_W-1:0] SLOW_ABOVE = PFD_W'((FULL_SCALE * 6) / 10);
  localparam logic [PFD_W-1:0] FAST_BELOW = PFD_W'((FULL_SCALE * 21) / 100);

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DRIVE = 2'd1,
    ST_DECAY = 2'd2,
    ST_HOLD  = 2'd3
  } state_e;

  state_e curState, nxtState;
  decay_e pickMode;
  logic   stopBridge;

  assign stopBridge = fault || !enable;

  // decay style for the coming off-time
  always_comb begin
    if (!currentFalling)             pickMode = DK_SLOW;
    else if (pfdLevel > SLOW_ABOVE)  pickMode = DK_SLOW;
    else if (pfdLevel < FAST_BELOW)  pickMode = DK_FAST;
    else                             pickMode = DK_MIXED;
  end

  always_comb begin
    nxtState         = curState;
    strobe.loadBlank = 1'b0;
    strobe.loadOff   = 1'b0;
    strobe.decayMode = pickMode;
    if (stopBridge) begin
      nxtState = ST_OFF;
    end else if (dacZero) begin
      nxtState = ST_HOLD;
    end else begin
      case (curState)
        ST_OFF, ST_HOLD: begin
          nxtState         = ST_DRIVE;
          strobe.loadBlank = 1'b1;
        end
        ST_DRIVE: begin
          if (blankDone && tripIn) begin
            nxtState       = ST_DECAY;
            strobe.loadOff = 1'b1;
          end
        end
        ST_DECAY: begin
          if (offLast) begin
            nxtState         = ST_DRIVE;
            strobe.loadBlank = 1'b1;
          end
        end
        default: nxtState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OFF;
    else       curState <= nxtState;
  end

  always_comb begin
    case (curState)
      ST_DRIVE: phase = PH_DRIVE;
      ST_DECAY: phase = fastActive ? PH_FAST : PH_SLOW;
      ST_HOLD:  phase = PH_SLOW;
      default:  phase = PH_OFF;
    endcase
  end

  AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (fault || !enable) |=> (phase == PH_OFF));  // R1

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_DRIVE && !blankDone && enable && !fault && !dacZero)
      |=> (curState == ST_DRIVE));  // R3

  AST_OFF_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_DECAY && offLast && enable && !fault && !dacZero)
      |=> (phase == PH_DRIVE));  // R4

  AST_ZERO_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    (dacZero && enable && !fault) |=> (phase == PH_SLOW));  // R9

endmodule

// File: rtl/pwmChopper.sv
module pwmChopper
  import chop_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PFD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             fault,
  input  logic             tripIn,
  input  logic             dacZero,
  input  logic             polarity,
  input  logic             currentFalling,
  input  logic [PFD_W-1:0] pfdLevel,
  input  logic [CNT_W-1:0] offCycles,
  input  logic [CNT_W-1:0] blankCycles,
  input  logic [CNT_W-1:0] fastCycles,
  output logic [1:0]       phase,
  output logic             hiA,
  output logic             loA,
  output logic             hiB,
  output logic             loB
);

  chop_strobe_t strobe;
  phase_e       phaseCur;
  logic         blankDone;
  logic         offLast;
  logic         fastActive;

  chopControl #(.PFD_W(PFD_W)) i_control (
    .clk            (clk),
    .rstN           (rstN),
    .enable         (enable),
    .fault          (fault),
    .tripIn         (tripIn),
    .dacZero        (dacZero),
    .currentFalling (currentFalling),
    .pfdLevel       (pfdLevel),
    .blankDone      (blankDone),
    .offLast        (offLast),
    .fastActive     (fastActive),
    .strobe         (strobe),
    .phase          (phaseCur)
  );

  chopTimers #(.CNT_W(CNT_W)) i_timers (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .offCycles   (offCycles),
    .blankCycles (blankCycles),
    .fastCycles  (fastCycles),
    .blankDone   (blankDone),
    .offLast     (offLast),
    .fastActive  (fastActive)
  );

  assign phase = phaseCur;

  // gate decode: diagonal pair in drive, low side of pair in slow decay
  always_comb begin
    hiA = 1'b0;
    loA = 1'b0;
    hiB = 1'b0;
    loB = 1'b0;
    case (phaseCur)
      PH_DRIVE: begin
        hiA = !polarity;
        loB = !polarity;
        hiB = polarity;
        loA = polarity;
      end
      PH_SLOW: begin
        loB = !polarity;
        loA = polarity;
      end
      default: ;
    endcase
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rstN)
    !(hiA && loA) && !(hiB && loB));  // R2

  AST_OFF_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd0 || phase == 2'd2) |-> !(hiA || loA || hiB || loB));  // R6

endmodule

// File: tb/test_pwmChopper.sv
`timescale 1ns/1ps
module test_pwmChopper;

  localparam int CNT_W = 16;
  localparam int PFD_W = 8;
  localparam logic [1:0] P_OFF = 2'd0, P_DRV = 2'd1, P_FST = 2'd2, P_SLW = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1, fault = 1'b0, tripIn = 1'b0, dacZero = 1'b0;
  logic polarity = 1'b0, currentFalling = 1'b0;
  logic [PFD_W-1:0] pfdLevel = '0;
  logic [CNT_W-1:0] offCycles = 16'd10, blankCycles = 16'd3, fastCycles = 16'd0;
  logic [1:0] phase;
  logic hiA, loA, hiB, loB;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwmChopper #(.CNT_W(CNT_W), .PFD_W(PFD_W)) i_pwmChopper (
    .clk(clk), .rstN(rstN), .enable(enable), .fault(fault), .tripIn(tripIn),
    .dacZero(dacZero), .polarity(polarity), .currentFalling(currentFalling),
    .pfdLevel(pfdLevel), .offCycles(offCycles), .blankCycles(blankCycles),
    .fastCycles(fastCycles), .phase(phase), .hiA(hiA), .loA(loA), .hiB(hiB), .loB(loB)
  );

  typedef struct packed {
    logic [15:0] off;
    logic [15:0] blank;
    logic [15:0] fast;
    logic [7:0]  pfd;
    logic        falling;
    logic        pol;
    int          expD;
    int          expF;
    int          expS;
  } vec_t;

  // comparator held high throughout every vector
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{16'd10, 16'd3, 16'd4, 8'd100, 1'b1, 1'b0, 4, 4, 6},   // R8 mixed
    '{16'd10, 16'd3, 16'd4, 8'd200, 1'b1, 1'b0, 4, 0, 10},  // R7 slow setting
    '{16'd10, 16'd3, 16'd4, 8'd20,  1'b1, 1'b1, 4, 10, 0},  // R7 fast, R6
    '{16'd10, 16'd3, 16'd4, 8'd20,  1'b0, 1'b0, 4, 0, 10},  // R7 not falling
    '{16'd6,  16'd0, 16'd9, 8'd100, 1'b1, 1'b0, 1, 6, 0},   // R8 clamp
    '{16'd0,  16'd2, 16'd0, 8'd100, 1'b1, 1'b1, 3, 0, 1},   // R4 zero off-time
    '{16'd5,  16'd1, 16'd2, 8'd153, 1'b1, 1'b0, 2, 2, 3},   // R7 upper edge mixed
    '{16'd5,  16'd1, 16'd2, 8'd154, 1'b1, 1'b0, 2, 0, 5},   // R7 upper edge slow
    '{16'd5,  16'd1, 16'd2, 8'd53,  1'b1, 1'b1, 2, 2, 3},   // R7 lower edge mixed
    '{16'd5,  16'd1, 16'd2, 8'd52,  1'b1, 1'b0, 2, 5, 0},   // R7 lower edge fast
    '{16'd3,  16'd5, 16'd0, 8'd100, 1'b1, 1'b1, 6, 0, 3}    // R3 long blank
  };

  function automatic logic [3:0] expGates(logic [1:0] ph, logic pol);
    case (ph)
      P_DRV:   return pol ? 4'b0110 : 4'b1001;
      P_SLW:   return pol ? 4'b0100 : 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkGates(string req, logic pol);
    logic [3:0] g;
    g = {hiA, loA, hiB, loB};
    check(g == expGates(phase, pol), req, int'(g), int'(expGates(phase, pol)));
  endtask

  task automatic countPhase(logic [1:0] ph, logic pol, string req, output int n);
    n = 0;
    while (phase == ph && n < 200) begin
      if (n == 0) checkGates(req, pol);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    finishRun();
  end

  initial begin
    int d, f, s, d2, bad;
    // R1: reset state
    @(negedge clk);
    check(phase == P_OFF, "R1 reset phase", phase, P_OFF);
    checkGates("R1 reset gates", 1'b0);
    rstN = 1'b1;

    // table: each vector measures drive, fast, slow and the next drive
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      enable = 1'b0;
      tripIn = 1'b1;
      offCycles = VECS[i].off;
      blankCycles = VECS[i].blank;
      fastCycles = VECS[i].fast;
      pfdLevel = VECS[i].pfd;
      currentFalling = VECS[i].falling;
      polarity = VECS[i].pol;
      @(negedge clk);
      check(phase == P_OFF, "R1 disabled", phase, P_OFF);
      enable = 1'b1;
      @(negedge clk);
      check(phase == P_DRV, "R2 drive after enable", phase, P_DRV);
      countPhase(P_DRV, VECS[i].pol, "R2 drive gates", d);
      countPhase(P_FST, VECS[i].pol, "R6 fast gates", f);
      countPhase(P_SLW, VECS[i].pol, "R5 slow gates", s);
      countPhase(P_DRV, VECS[i].pol, "R4 redrive gates", d2);
      check(d == VECS[i].expD, "R3 drive length", d, VECS[i].expD);
      check(f == VECS[i].expF, "R7/R8 fast length", f, VECS[i].expF);
      check(s == VECS[i].expS, "R7/R8 slow length", s, VECS[i].expS);
      check(d2 == VECS[i].expD, "R4 blank restart on expiry", d2, VECS[i].expD);
      check((f + s) == ((VECS[i].off == 0) ? 1 : int'(VECS[i].off)),
            "R4 off-time length", f + s, (VECS[i].off == 0) ? 1 : int'(VECS[i].off));
    end

    // R3: comparator high only inside the blanking window is ignored
    @(negedge clk);
    enable = 1'b0; tripIn = 1'b0;
    offCycles = 16'd5; blankCycles = 16'd4; fastCycles = 16'd0;
    currentFalling = 1'b0; pfdLevel = 8'd100; polarity = 1'b0;
    @(negedge clk);
    enable = 1'b1; tripIn = 1'b1;
    repeat (5) @(negedge clk);
    check(phase == P_DRV, "R3 blank window", phase, P_DRV);
    tripIn = 1'b0;
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (phase != P_DRV) bad++;
    end
    check(bad == 0, "R3 no trip after blanked pulse", bad, 0);
    tripIn = 1'b1;
    @(negedge clk);
    check(phase == P_SLW, "R3 trip after blanking", phase, P_SLW);
    checkGates("R5 slow pol0", 1'b0);

    // R1/R10: fault together with trip and zero flag
    fault = 1'b1;
    @(negedge clk);
    check(phase == P_OFF, "R1 fault off", phase, P_OFF);
    checkGates("R1 fault gates", 1'b0);
    dacZero = 1'b1;
    repeat (3) @(negedge clk);
    check(phase == P_OFF, "R10 fault over zero", phase, P_OFF);
    fault = 1'b0;
    @(negedge clk);
    check(phase == P_SLW, "R9 zero slow", phase, P_SLW);
    checkGates("R9 zero gates", 1'b0);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (phase != P_SLW) bad++;
    end
    check(bad == 0, "R9 zero never drives", bad, 0);
    dacZero = 1'b0;
    @(negedge clk);
    check(phase == P_DRV, "R9 drive after zero", phase, P_DRV);
    countPhase(P_DRV, 1'b0, "R9 drive gates", d);
    check(d == 5, "R9 full blanking after zero", d, 5);
    enable = 1'b0;
    @(negedge clk);
    check(phase == P_OFF, "R1 enable low", phase, P_OFF);
    checkGates("R1 enable low gates", 1'b0);

    finishRun();
  end

endmodule